// File: doc/BRIEF.md
# Serial Display Command and Pixel Transmitter

This block moves bytes from a simple valid/ready stream onto a write-only serial link to a display controller. Each byte carries a flag that marks it as a command or as data. The block shifts the byte out most significant bit first on one data line. It drives a select line low for commands and high for data, and it brackets a group of bytes with an active-low chip select. The serial clock idles high. Data changes on the falling edge so that it is stable when the display samples it on the rising edge.

A sequencer above the block feeds a command byte followed by its parameter bytes and sets a `last` flag on the final byte of the group. Chip select stays low across the whole group and rises once that final byte has been shifted. A memory-write group is the command byte 0x2C followed by 16-bit RGB565 pixels, two bytes per pixel, high byte first. The sequencer also drives the panel reset request, and the block returns it as a registered active-low reset pin. The serial clock rate is the system clock divided by twice `HALF_DIV`.

Top module: `lcd_spi_tx`

## Requirements
- R1: While the block is held in reset, `spi_cs_n` and `spi_sclk` are 1, `in_ready` is 1 and `panel_rst_n` is 0.
- R2: Every accepted byte is sent most significant bit first. The eight values of `spi_mosi` sampled on the eight rising `spi_sclk` edges inside chip select equal that byte, and bytes appear in the order they were accepted.
- R3: `spi_dc` equals the byte's `in_is_data` flag (0 = command, 1 = data). It takes that value on the accept edge, which is one half period before the first falling clock edge, and it stays unchanged through the byte's last rising edge.
- R4: `spi_sclk` is 1 whenever no byte is being shifted, both with chip select high and in the gap between bytes of one group.
- R5: Each serial clock half period lasts exactly `HALF_DIV` system clocks, and each byte has exactly eight rising edges.
- R6: After the edge that accepts a byte, `in_ready` stays 0 for (2*8+1)*`HALF_DIV` system clocks and then returns to 1.
- R7: `spi_cs_n` falls on the edge that accepts the first byte of a group. It stays 0 across later bytes and idle gaps, and rises (2*8+1)*`HALF_DIV` clocks after the accept edge of the byte flagged `in_last`. It never rises part-way through a byte.
- R8: `panel_rst_n` equals the inverse of `panel_rst_req` one system clock later.
- R9: A memory-write group (command 0x2C, then RGB565 pixels sent as high byte then low byte) goes out in order inside a single chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | WORD_W | Byte to send |
| in_is_data | input | 1 | 1 = data or parameter byte, 0 = command byte |
| in_last | input | 1 | Byte closes the chip-select group |
| panel_rst_req | input | 1 | Request to hold the panel in reset |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_dc | output | 1 | Command (0) / data (1) select |
| panel_rst_n | output | 1 | Panel reset, active low |

## Verification
A byte accepted on edge E puts `spi_cs_n`, `spi_dc` and the first data bit on the pins right after E. Its k-th clock phase starts at E + k*`HALF_DIV`, and the ready and chip-select results land at E + 17*`HALF_DIV`. The panel reset pin follows its request one clock later. The bench drives inputs on falling clock edges and reads every output on falling edges. It counts those edges from the accept to compare the ready-low length and the chip-select level against the exact figure. A falling-edge monitor rebuilds (select, byte) pairs from the rising serial-clock edges and times every half period. The sweep covers all 256 byte values with both flag settings.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;

  // link controller states
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,   // chip select high, waiting for a first byte
    LK_OPEN  = 2'd1,   // chip select low, waiting for the next byte of a group
    LK_SHIFT = 2'd2    // a byte is on the wire
  } link_state_t;

  // half periods in one byte: one setup half, then a low and a high half per bit
  function automatic int unsigned halves_per_byte(input int unsigned word_w);
    return 2 * word_w + 1;
  endfunction

endpackage

// File: rtl/lcd_half_timer.sv
module lcd_half_timer #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick = run && (cnt_q == TOP);

  always_comb begin
    cnt_en = 1'b1;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcd_bit_seq.sv
module lcd_bit_seq #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_byte,
  input  logic              tick,
  output logic              sclk,
  output logic              mosi,
  output logic              byte_done
);
  localparam int unsigned LAST_PH = lcd_tx_pkg::halves_per_byte(WORD_W) - 1;
  localparam int unsigned PW      = $clog2(LAST_PH + 1);
  localparam logic [PW-1:0] LAST  = PW'(LAST_PH);

  logic [PW-1:0]     ph_q, ph_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic              upd_en;

  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign byte_done = tick && (ph_q == LAST);
  assign upd_en    = load || tick;

  always_comb begin
    ph_d   = ph_q;
    sh_d   = sh_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    if (load) begin
      ph_d   = '0;
      sh_d   = load_byte;
      sclk_d = 1'b1;
      mosi_d = load_byte[WORD_W-1];
    end else if (tick) begin
      if (ph_q == LAST) begin
        ph_d   = '0;
        sclk_d = 1'b1;
      end else begin
        ph_d = ph_q + PW'(1);
        if (!ph_q[0]) begin
          // falling edge: next bit goes out
          sclk_d = 1'b0;
          mosi_d = sh_q[WORD_W-1];
          sh_d   = {sh_q[WORD_W-2:0], 1'b0};
        end else begin
          sclk_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
    end else if (upd_en) begin
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
    end
  end
endmodule

// File: rtl/lcd_link_ctl.sv
module lcd_link_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_is_data,
  input  logic in_last,
  input  logic byte_done,
  output logic in_ready,
  output logic load,
  output logic run,
  output logic cs_n,
  output logic dc
);
  import lcd_tx_pkg::*;

  link_state_t st_q, st_d;
  logic        cs_n_q, cs_n_d;
  logic        dc_q, dc_d;
  logic        last_q, last_d;

  assign in_ready = (st_q != LK_SHIFT);
  assign load     = in_valid && in_ready;
  assign run      = (st_q == LK_SHIFT);
  assign cs_n     = cs_n_q;
  assign dc       = dc_q;

  always_comb begin
    st_d   = st_q;
    cs_n_d = cs_n_q;
    dc_d   = dc_q;
    last_d = last_q;
    case (st_q)
      LK_IDLE, LK_OPEN: begin
        if (load) begin
          st_d   = LK_SHIFT;
          cs_n_d = 1'b0;
          dc_d   = in_is_data;
          last_d = in_last;
        end
      end
      LK_SHIFT: begin
        if (byte_done) begin
          if (last_q) begin
            st_d   = LK_IDLE;
            cs_n_d = 1'b1;
          end else begin
            st_d = LK_OPEN;
          end
        end
      end
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      cs_n_q <= 1'b1;
      dc_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      dc_q   <= dc_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_byte,
  input  logic              in_is_data,
  input  logic              in_last,
  input  logic              panel_rst_req,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_dc,
  output logic              panel_rst_n
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic ready_i, load, run, tick, byte_done;

  lcd_link_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .in_valid   (in_valid),
    .in_is_data (in_is_data),
    .in_last    (in_last),
    .byte_done  (byte_done),
    .in_ready   (ready_i),
    .load       (load),
    .run        (run),
    .cs_n       (spi_cs_n),
    .dc         (spi_dc)
  );

  lcd_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (run),
    .tick  (tick)
  );

  lcd_bit_seq #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (load),
    .load_byte (in_byte),
    .tick      (tick),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .byte_done (byte_done)
  );

  assign in_ready = ready_i;

  // panel reset: registered, held low while the block is in reset
  logic prst_n_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) prst_n_q <= 1'b0;
    else          prst_n_q <= !panel_rst_req;
  end
  assign panel_rst_n = prst_n_q;

endmodule

// File: rtl/lcd_spi_tx_chk.sv
module lcd_spi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic panel_rst_req,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_dc,
  input logic panel_rst_n
);
  // R4
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R6
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  dc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !spi_sclk) |-> $stable(spi_dc));

  // R2
  mosi_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $rose(spi_sclk)) |-> $stable(spi_mosi));

  // R7
  cs_open_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(in_valid && in_ready));

  // R8
  panel_reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_rst_req) |=> !panel_rst_n);
endmodule

bind lcd_spi_tx lcd_spi_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .panel_rst_req (panel_rst_req),
  .spi_cs_n      (spi_cs_n),
  .spi_sclk      (spi_sclk),
  .spi_mosi      (spi_mosi),
  .spi_dc        (spi_dc),
  .panel_rst_n   (panel_rst_n)
);

// File: tb/sim_lcd_spi_tx.sv
module sim_lcd_spi_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int W          = 8;
  localparam int BYTE_CYC   = (2 * W + 1) * HALF;
  localparam int WDOG_LIM   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_data = 1'b0, in_last = 1'b0, panel_rst_req = 1'b0;
  logic [W-1:0] in_byte = '0;
  logic in_ready, spi_cs_n, spi_sclk, spi_mosi, spi_dc, panel_rst_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_spi_tx #(.HALF_DIV(HALF), .WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .panel_rst_req(panel_rst_req), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_dc(spi_dc), .panel_rst_n(panel_rst_n)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ---------------- serial monitor ----------------
  logic [8:0] exp_q[$];
  logic [8:0] e;
  logic [W-1:0] rx = '0;
  logic dc0 = 1'b0;
  int bitcnt = 0;
  int since = 0;
  int cs_rises = 0;
  logic prev_sclk = 1'b1, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      since++;
      if (in_ready && !spi_sclk) chk(1'b0, "R4 sclk low while no byte shifts", 0, 1);
      if (spi_sclk != prev_sclk) begin
        if (!spi_cs_n) begin
          if (spi_sclk) begin
            chk(since == HALF, "R5 high half start", since, HALF);
            if (bitcnt == 0) dc0 = spi_dc;
            else if (spi_dc != dc0) chk(1'b0, "R3 dc moved inside byte", spi_dc, dc0);
            rx = {rx[W-2:0], spi_mosi};
            bitcnt++;
            if (bitcnt == W) begin
              bitcnt = 0;
              if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", {dc0, rx}, 0);
              else begin
                e = exp_q.pop_front();
                chk({dc0, rx} == e, "R2/R3 decoded pair", {dc0, rx}, e);
              end
            end
          end else if (bitcnt != 0) begin
            chk(since == HALF, "R5 low half start", since, HALF);
          end
        end
        since = 0;
      end
      if (!prev_cs && spi_cs_n) begin
        cs_rises++;
        chk(bitcnt == 0, "R7 cs rose inside byte", bitcnt, 0);
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic f, input logic [W-1:0] b, input logic l);
    int n;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = f; in_last = l;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({f, b});
    @(negedge clk);
    in_valid = 1'b0;
    chk(!spi_cs_n && spi_sclk, "R7 cs low after take", spi_cs_n, 0);
    chk(spi_dc == f, "R3 dc set at take", spi_dc, f);
    n = 1;
    while (!in_ready) begin
      @(negedge clk);
      if (!in_ready) n++;
    end
    chk(n == BYTE_CYC, "R6 ready low length", n, BYTE_CYC);
    chk(spi_cs_n == l, "R7 cs level after byte", spi_cs_n, l);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIM && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WDOG_LIM);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int r0;
    logic [15:0] px;
    idle(2);
    // R1 reset state
    chk(spi_cs_n && spi_sclk, "R1 cs/sclk in reset", {spi_cs_n, spi_sclk}, 3);
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk(panel_rst_n == 1'b0, "R1 panel reset held", panel_rst_n, 0);
    rst_n = 1'b1;
    idle(4);
    chk(panel_rst_n == 1'b1, "R8 panel reset released", panel_rst_n, 1);

    // R8 request follows one clock later
    @(negedge clk); panel_rst_req = 1'b1;
    @(negedge clk);
    chk(panel_rst_n == 1'b0, "R8 panel reset asserted", panel_rst_n, 0);
    panel_rst_req = 1'b0;
    @(negedge clk);
    chk(panel_rst_n == 1'b1, "R8 panel reset dropped", panel_rst_n, 1);

    // R2 R3 R5 sweep: all byte values as command and as data, one byte per group
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 256; v++) begin
        send(f[0], v[W-1:0], 1'b1);
      end
    end
    idle(3);
    chk(exp_q.size() == 0, "R2 all sweep bytes decoded", exp_q.size(), 0);
    chk(cs_rises == 512, "R7 one window per single-byte group", cs_rises, 512);

    // R7 group with idle gaps between bytes keeps cs low
    r0 = cs_rises;
    send(1'b0, 8'hB2, 1'b0);
    idle(7);
    chk(!spi_cs_n && spi_sclk, "R7 R4 cs low and sclk high in gap", {spi_cs_n, spi_sclk}, 1);
    send(1'b1, 8'h08, 1'b0);
    idle(1);
    send(1'b1, 8'h22, 1'b1);
    idle(3);
    chk(cs_rises == r0 + 1, "R7 one window for gapped group", cs_rises, r0 + 1);

    // R9 memory-write group: 0x2C then RGB565 pixels high byte first
    r0 = cs_rises;
    send(1'b0, 8'h2C, 1'b0);
    for (int p = 0; p < 6; p++) begin
      px = {5'(p * 5 + 1), 6'(p * 9 + 3), 5'(31 - p * 4)};
      send(1'b1, px[15:8], 1'b0);
      send(1'b1, px[7:0], p == 5);
    end
    idle(3);
    chk(exp_q.size() == 0 && cs_rises == r0 + 1, "R9 pixel group in one window",
        cs_rises - r0, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule